// File: doc/BRIEF.md
# Shared-Keystream Uniform and Binomial Coefficient Sampler

This block turns an 80-bit key and an 80-bit initialization vector into a stream of coefficients modulo q = 12289 for lattice-based cryptography. A single Trivium keystream generator, unrolled to advance 64 rounds per clock, supplies one 64-bit keystream word per cycle. A mode input chooses how each word is used. In uniform mode the word is split into four 16-bit chunks, and each chunk is kept or rejected. In binomial mode the word yields two centered-binomial samples that are folded into [0, q).

A one-cycle `start_i` pulse loads the key and IV into the 288-bit state. The core then runs 1152 warm-up rounds, which take 18 clocks. After that it produces one keystream word per clock until the next `start_i`. The mode is sampled every running cycle, so both samplers share one generator and can interleave word by word. Each output lane carries its own valid bit.

Top module: `trv_sampler`

## Requirements
- R1: After reset, and until the first `start_i`, `valid_o` is all zero.
- R2: After `start_i` is sampled on clock edge E0, the edges E1 to E18 only advance the state, and `valid_o` stays zero through all of them. Keystream word k is consumed at edge E(19+k), and its result appears on the outputs right after that edge.
- R3: In uniform mode (`mode_i` = 0), lane i takes keystream bits [16i+13:16i] as a 14-bit value v. Lane i is valid exactly when v < 12289, and then `coef_o` lane i equals v.
- R4: In binomial mode (`mode_i` = 1), lanes 2 and 3 are invalid and lanes 0 and 1 are valid. Lane p equals popcount(bits [32p+15:32p]) minus popcount(bits [32p+31:32p+16]), taken mod q.
- R5: A negative binomial difference d is output as 12289 + d. A non-negative difference is output unchanged.
- R6: Every valid lane value is below 12289.
- R7: The mode is sampled on each running edge and applies to that edge's word only. Changing the mode never alters the keystream sequence.
- R8: A `start_i` pulse during a run reloads the state. `valid_o` is zero right after the loading edge, and the new session's timing follows R2.
- R9: Key bit i loads Trivium state bit i+1, and IV bit i loads state bit i+94. State bits 286 to 288 are set to 1 and all other bits to 0. Keystream bit j of a word is the output of the j-th round of that cycle, with j = 0 first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Load key/IV and begin warm-up |
| mode_i | input | 1 | 0 = uniform rejection, 1 = centered binomial |
| key_i | input | 80 | Cipher key |
| iv_i | input | 80 | Initialization vector |
| valid_o | output | 4 | Per-lane valid |
| coef_o | output | 56 | Four 14-bit coefficients, lane i at bits [14i+13:14i] |

## Verification
The hardest situation to reach is a word-by-word mode change. The bench must know exactly which keystream word each mode value lands on, which means counting the load edge and the 18 warm-up edges precisely. The driver steps a behavioural Trivium model one word per running clock. It sets the mode for that same word and pushes the expected lane mask and values. Separate sessions cover a run that alternates the mode every cycle, and a restart issued while the block is still producing output.

// File: rtl/trv_pkg.sv
package trv_pkg;
  parameter int STATE_W  = 288;
  parameter int KEY_W    = 80;
  parameter int WORD_W   = 64;
  parameter int CHUNK_W  = 16;
  parameter int LANES    = WORD_W / CHUNK_W;
  parameter int PAIRS    = LANES / 2;
  parameter int QW       = 14;
  parameter int Q        = 12289;
  parameter int WARM_CYC = 18;
  parameter int CNT_W    = $clog2(WARM_CYC + 1);
  parameter int PC_W     = $clog2(CHUNK_W + 1);

  typedef logic [QW-1:0] coef_t;
  localparam coef_t Q_C = coef_t'(Q);

  typedef enum logic [1:0] {PH_IDLE, PH_WARM, PH_RUN} phase_e;
endpackage

// File: rtl/trv_core.sv
module trv_core
  import trv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [KEY_W-1:0]  key,
  input  logic [KEY_W-1:0]  iv,
  output logic [WORD_W-1:0] ks
);
  logic [STATE_W-1:0] st_q, st_adv, st_d;

  // WORD_W Trivium rounds unrolled; bit j of ks is round j's output.
  always_comb begin
    logic [STATE_W-1:0] s;
    logic t1, t2, t3;
    s  = st_q;
    ks = '0;
    for (int j = 0; j < WORD_W; j++) begin
      t1 = s[65]  ^ s[92];
      t2 = s[161] ^ s[176];
      t3 = s[242] ^ s[287];
      ks[j] = t1 ^ t2 ^ t3;
      t1 = t1 ^ (s[90]  & s[91])  ^ s[170];
      t2 = t2 ^ (s[174] & s[175]) ^ s[263];
      t3 = t3 ^ (s[285] & s[286]) ^ s[68];
      s  = {s[286:177], t2, s[175:93], t1, s[91:0], t3};
    end
    st_adv = s;
  end

  always_comb begin
    st_d = st_q;
    if (load)     st_d = {3'b111, 112'b0, iv, 13'b0, key};
    else if (adv) st_d = st_adv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            st_q <= '0;
    else if (load || adv)  st_q <= st_d;
  end
endmodule

// File: rtl/trv_parse.sv
module trv_parse
  import trv_pkg::*;
(
  input  logic [WORD_W-1:0]     ks,
  output logic [LANES-1:0]      ok,
  output logic [LANES*QW-1:0]   coef
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    coef_t v;
    assign v = ks[i*CHUNK_W +: QW];
    assign ok[i] = (v < Q_C);
    assign coef[i*QW +: QW] = v;
  end
endmodule

// File: rtl/trv_binom.sv
module trv_binom
  import trv_pkg::*;
(
  input  logic [WORD_W-1:0]   ks,
  output logic [PAIRS*QW-1:0] coef
);
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    logic [PC_W-1:0] a, b;
    assign a = PC_W'($countones(ks[2*p*CHUNK_W +: CHUNK_W]));
    assign b = PC_W'($countones(ks[(2*p+1)*CHUNK_W +: CHUNK_W]));
    assign coef[p*QW +: QW] = (a >= b) ? coef_t'(a - b)
                                       : Q_C - coef_t'(b - a);
  end
endmodule

// File: rtl/trv_sampler.sv
module trv_sampler
  import trv_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start_i,
  input  logic                mode_i,
  input  logic [79:0]         key_i,
  input  logic [79:0]         iv_i,
  output logic [3:0]          valid_o,
  output logic [55:0]         coef_o
);
  phase_e             ph_q, ph_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               adv;
  logic [WORD_W-1:0]  ks;
  logic [LANES-1:0]   p_ok;
  logic [LANES*QW-1:0] p_coef;
  logic [PAIRS*QW-1:0] b_coef;
  logic [LANES-1:0]   val_d, val_q;
  logic [LANES*QW-1:0] coef_d, coef_q;
  logic               out_en;

  trv_core u_core (
    .clk(clk), .rst_n(rst_n), .load(start_i), .adv(adv),
    .key(key_i), .iv(iv_i), .ks(ks)
  );
  trv_parse u_parse (.ks(ks), .ok(p_ok), .coef(p_coef));
  trv_binom u_binom (.ks(ks), .coef(b_coef));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    adv   = 1'b0;
    if (start_i) begin
      ph_d  = PH_WARM;
      cnt_d = '0;
    end else begin
      case (ph_q)
        PH_WARM: begin
          adv   = 1'b1;
          cnt_d = cnt_q + 1'b1;
          if (cnt_q == CNT_W'(WARM_CYC - 1)) ph_d = PH_RUN;
        end
        PH_RUN:  adv = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    val_d  = '0;
    coef_d = '0;
    if (!start_i && ph_q == PH_RUN) begin
      if (mode_i) begin
        val_d[PAIRS-1:0]      = '1;
        coef_d[PAIRS*QW-1:0]  = b_coef;
      end else begin
        val_d  = p_ok;
        for (int i = 0; i < LANES; i++)
          if (p_ok[i]) coef_d[i*QW +: QW] = p_coef[i*QW +: QW];
      end
    end
  end

  assign out_en = start_i || (ph_q != PH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      val_q  <= '0;
      coef_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      if (out_en) begin
        val_q  <= val_d;
        coef_q <= coef_d;
      end
    end
  end

  assign valid_o = val_q;
  assign coef_o  = coef_q;

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_IDLE) |-> (valid_o == '0));
  assert_warm_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_WARM) |-> (cnt_q < CNT_W'(WARM_CYC)) && (valid_o == '0));
  assert_binom_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q == PH_RUN && mode_i && !start_i) |=> (valid_o[LANES-1:PAIRS] == '0));
  assert_restart_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (valid_o == '0));
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o[i] |-> (coef_o[i*QW +: QW] < Q_C));
  end
  for (genvar p = 0; p < PAIRS; p++) begin : g_bchk
    assert_fold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ph_q == PH_RUN && mode_i && !start_i) |=>
        (coef_o[p*QW +: QW] <= coef_t'(CHUNK_W) ||
         coef_o[p*QW +: QW] >= Q_C - coef_t'(CHUNK_W)));
  end
endmodule

// File: tb/tb_trv_sampler.sv
`timescale 1ns/1ps
module tb_trv_sampler;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, mode_i;
  logic [79:0] key_i, iv_i;
  logic [3:0]  valid_o;
  logic [55:0] coef_o;

  int checks = 0, errors = 0;
  bit watch = 1'b0;
  bit done = 1'b0;
  logic [3:0]  exp_v_q[$];
  logic [55:0] exp_c_q[$];
  logic [287:0] mdl;

  always #4 clk = ~clk;

  trv_sampler dut (.clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
    .key_i(key_i), .iv_i(iv_i), .valid_o(valid_o), .coef_o(coef_o));

  function automatic logic tp(logic [287:0] s, int n); return s[n-1]; endfunction

  // Behavioural Trivium: state s_1..s_288 held as s[0..287] (R9).
  function automatic logic [63:0] model_word(inout logic [287:0] s);
    logic [63:0] z;
    logic a, b, c;
    for (int r = 0; r < 64; r++) begin
      a = tp(s,66) ^ tp(s,93);
      b = tp(s,162) ^ tp(s,177);
      c = tp(s,243) ^ tp(s,288);
      z[r] = a ^ b ^ c;
      a = a ^ (tp(s,91) & tp(s,92)) ^ tp(s,171);
      b = b ^ (tp(s,175) & tp(s,176)) ^ tp(s,264);
      c = c ^ (tp(s,286) & tp(s,287)) ^ tp(s,69);
      for (int n = 288; n > 178; n--) s[n-1] = s[n-2];
      s[177] = b;
      for (int n = 177; n > 94; n--) s[n-1] = s[n-2];
      s[93] = a;
      for (int n = 93; n > 1; n--) s[n-1] = s[n-2];
      s[0] = c;
    end
    return z;
  endfunction

  task automatic fail_line(string req, string what, longint act, longint exp);
    errors++;
    $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
  endtask

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) fail_line(req, what, act, exp);
  endtask

  // Driver: one session = load, 18 warm-up clocks, nw words with a mode pattern.
  // pat: 0 all uniform, 1 all binomial, 2 alternating.
  task automatic session(logic [79:0] k, logic [79:0] v, int pat, int nw);
    logic [63:0] z;
    logic [3:0]  ev;
    logic [55:0] ec;
    int a, b, m;
    @(negedge clk);
    watch = 1'b0;
    key_i = k; iv_i = v; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R8", "valid after load edge", valid_o, 0);
    mdl = 288'b0;
    for (int i = 0; i < 80; i++) begin mdl[i] = k[i]; mdl[93+i] = v[i]; end
    mdl[285] = 1'b1; mdl[286] = 1'b1; mdl[287] = 1'b1;
    for (int w = 0; w < 18; w++) begin
      z = model_word(mdl);
      @(negedge clk);
      chk("R2", "valid during warm-up", valid_o, 0);
    end
    watch = 1'b1;
    for (int w = 0; w < nw; w++) begin
      m = (pat == 2) ? (w % 2) : pat;
      mode_i = m[0];
      z = model_word(mdl);
      ev = '0; ec = '0;
      if (m == 0) begin                       // R3
        for (int l = 0; l < 4; l++)
          if (z[16*l +: 14] < 14'd12289) begin
            ev[l] = 1'b1; ec[14*l +: 14] = z[16*l +: 14];
          end
      end else begin                          // R4, R5
        for (int p = 0; p < 2; p++) begin
          a = $countones(z[32*p +: 16]);
          b = $countones(z[32*p+16 +: 16]);
          ev[p] = 1'b1;
          ec[14*p +: 14] = (a >= b) ? 14'(a - b) : 14'(12289 - (b - a));
        end
      end
      exp_v_q.push_back(ev);
      exp_c_q.push_back(ec);
      @(negedge clk);
    end
    watch = 1'b0;
    chk("R7", "expected words left unconsumed", exp_v_q.size(), 0);
  endtask

  // Monitor: compares each running word's lanes against the scoreboard.
  always @(posedge clk) begin
    #1;
    if (watch) begin
      logic [3:0]  ev;
      logic [55:0] ec;
      if (exp_v_q.size() == 0) begin
        checks++;
        fail_line("R2", "output with nothing expected", valid_o, 0);
      end else begin
        ev = exp_v_q.pop_front();
        ec = exp_c_q.pop_front();
        chk("R3/R4", "valid mask", valid_o, ev);
        for (int l = 0; l < 4; l++)
          if (ev[l]) begin
            chk("R3/R4/R5/R9", "lane value", coef_o[14*l +: 14], ec[14*l +: 14]);
            checks++;
            if (coef_o[14*l +: 14] >= 14'd12289)
              fail_line("R6", "lane out of range", coef_o[14*l +: 14], 12288);
          end
      end
    end
  end

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    fail_line("ALL", "watchdog expired", 0, 1);
    finish_up();
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; mode_i = 1'b0; key_i = '0; iv_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1", "valid before any start", valid_o, 0);
    session(80'h0123_4567_89AB_CDEF_FEDC, 80'h0F1E_2D3C_4B5A_6978_8796, 0, 40);
    session(80'hA5A5_5A5A_C3C3_3C3C_9999, 80'h1111_2222_3333_4444_5555, 1, 40);
    session(80'h0, 80'h0, 2, 30);                        // R7 interleaving
    // R8: restart while the previous session is still producing words
    session(80'hDEAD_BEEF_0000_FFFF_1234, 80'h8000_0000_0000_0000_0001, 1, 6);
    session(80'h8000_0000_0000_0000_0001, 80'hDEAD_BEEF_0000_FFFF_1234, 2, 24);
    repeat (2) @(negedge clk);
    finish_up();
  end
endmodule